// File: doc/BRIEF.md
# Inline Byte-Run Mismatch Comparator

This block executes the compare-run branch of a packet-filter engine. The branch carries a run of literal bytes inline in the program. A launch supplies four values: the program address of the first literal byte, the packet offset taken from the register that the instruction selects, the run length N and the signed-free jump offset. The block then walks both memories in lock-step through one program read port and one packet read port, comparing one byte pair per cycle.

If any pair differs, the branch is taken. The next program counter is then the address just past the literal run plus the jump offset. If every pair matches, the branch falls through to the address just past the last literal byte. A run of length zero counts as a match. A run that would read past the end of the packet is refused with a bounds error, and no compare is made. Completion is marked by a one-cycle done pulse. The result stays on the outputs until the next launch. Register file and instruction decode sit outside the block.

Top module: `seqmis_cmp`

## Requirements
- R1: After synchronous reset, done, busy, taken, bounds_err and both read enables are 0 and next_pc is 0.
- R2: For an accepted launch with N > 0, the block issues one read per cycle on each port. For i counting from 0, the program address is lit_addr+i and the packet address is pkt_offset+i, and both are issued in the same cycle.
- R3: When all N byte pairs are equal, taken is 0, bounds_err is 0 and next_pc is lit_addr+N. Done rises at the (N+2)th rising edge, counting the edge that samples start as the first. Exactly N reads are issued on each port.
- R4: When byte k (0-based) is the first unequal pair, taken is 1 and next_pc is lit_addr+N+jump_off. Done rises at the (k+3)th rising edge. No more than min(k+2, N) reads are issued on each port.
- R5: A launch with N = 0 that is in bounds gives done at the 1st rising edge with taken 0, bounds_err 0 and next_pc = lit_addr. It issues no read.
- R6: If pkt_offset+N > pkt_len (unsigned, without wrap), bounds_err is 1 and taken is 0. Done rises at the 1st rising edge and no read is issued. A span that ends exactly at pkt_len is accepted. While a run is active, every packet address is below pkt_len.
- R7: Done is high for exactly one cycle. Taken, bounds_err and next_pc hold their values until the next accepted launch.
- R8: A start pulse while busy is 1 is ignored: the running compare completes with the result its own launch calls for.
- R9: Bytes compare as exact 8-bit values, so a difference in bit 7 alone is a mismatch. Program addresses and next_pc wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| lit_addr | input | AW | Program address of the first literal byte |
| jump_off | input | AW | Offset added to the post-run address when taken |
| pkt_offset | input | PW | Packet byte offset where comparison starts |
| pkt_len | input | PW | Packet length in bytes |
| byte_count | input | CW | Number of bytes N to compare |
| prog_rd_en | output | 1 | Program memory read enable |
| prog_rd_addr | output | AW | Program memory read address |
| prog_rd_data | input | 8 | Program byte, valid one cycle after the read |
| pkt_rd_en | output | 1 | Packet memory read enable |
| pkt_rd_addr | output | PW | Packet memory read address |
| pkt_rd_data | input | 8 | Packet byte, valid one cycle after the read |
| busy | output | 1 | A compare run is in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken (a mismatch was found) |
| bounds_err | output | 1 | The span ran past the packet end |
| next_pc | output | AW | Next program counter |

## Verification
Both memories return data one cycle after the read, so each result arrives at a fixed edge. Bounds and zero-length results come at the first edge, counting the edge that samples start. A full match comes at edge N+2, and a first mismatch at byte k comes at edge k+3. Each scenario drives start on a falling edge and then counts falling edges until done is seen. It compares that count with the number the requirement gives, and reads taken, bounds_err and next_pc at that same falling edge. The bench also logs every read address as it is issued, so it can check the per-port read count and address order against the requirement.

// File: rtl/seqmis_pkg.sv
package seqmis_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic taken;
        logic bounds;
    } outcome_t;

    // True when a span of cnt bytes starting at off stays within len.
    function automatic logic span_fits(input logic [32:0] off,
                                       input logic [32:0] cnt,
                                       input logic [32:0] len);
        logic [33:0] span_end;
        span_end = {1'b0, off} + {1'b0, cnt};
        return span_end <= {1'b0, len};
    endfunction

endpackage

// File: rtl/seqmis_walk.sv
module seqmis_walk #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          active,
    input  logic          stop,
    input  logic [CW-1:0] cnt,
    output logic          issue,
    output logic [CW-1:0] idx,
    output logic          cmp_vld,
    output logic [CW-1:0] cmp_idx
);
    assign issue = active && (idx != cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            cmp_vld <= 1'b0;
            cmp_idx <= '0;
        end else if (launch) begin
            idx     <= '0;
            cmp_vld <= 1'b0;
        end else begin
            cmp_vld <= issue && !stop;
            if (issue) begin
                idx     <= idx + 1'b1;
                cmp_idx <= idx;
            end
        end
    end
endmodule

// File: rtl/seqmis_judge.sv
module seqmis_judge #(
    parameter int CW = 16
) (
    input  logic                         cmp_vld,
    input  logic [CW-1:0]                cmp_idx,
    input  logic [CW-1:0]                cnt,
    input  logic [seqmis_pkg::BYTE_W-1:0] lit_byte,
    input  logic [seqmis_pkg::BYTE_W-1:0] pkt_byte,
    output logic                         differ,
    output logic                         last_ok,
    output logic                         finish
);
    logic at_last;

    always_comb begin
        at_last = (cmp_idx == cnt - 1'b1);
        differ  = cmp_vld && (lit_byte != pkt_byte);
        last_ok = cmp_vld && !differ && at_last;
        finish  = differ || last_ok;
    end
endmodule

// File: rtl/seqmis_cmp.sv
module seqmis_cmp
    import seqmis_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 16,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     lit_addr,
    input  logic [AW-1:0]     jump_off,
    input  logic [PW-1:0]     pkt_offset,
    input  logic [PW-1:0]     pkt_len,
    input  logic [CW-1:0]     byte_count,
    output logic              prog_rd_en,
    output logic [AW-1:0]     prog_rd_addr,
    input  logic [BYTE_W-1:0] prog_rd_data,
    output logic              pkt_rd_en,
    output logic [PW-1:0]     pkt_rd_addr,
    input  logic [BYTE_W-1:0] pkt_rd_data,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic              bounds_err,
    output logic [AW-1:0]     next_pc
);
    run_state_e    st;
    logic [AW-1:0] lit_q, end_q, tgt_q;
    logic [PW-1:0] off_q, len_q;
    logic [CW-1:0] cnt_q;
    outcome_t      res_q;

    logic          launch, fits, issue, cmp_vld, differ, last_ok, finish;
    logic [CW-1:0] idx, cmp_idx;
    logic [AW-1:0] end_in;

    assign launch = start && (st == ST_IDLE);
    assign fits   = span_fits(33'(pkt_offset), 33'(byte_count), 33'(pkt_len));
    assign end_in = lit_addr + AW'(byte_count);

    seqmis_walk #(.CW(CW)) walk_i (
        .clk(clk), .rst(rst), .launch(launch),
        .active(st == ST_RUN), .stop(finish), .cnt(cnt_q),
        .issue(issue), .idx(idx), .cmp_vld(cmp_vld), .cmp_idx(cmp_idx)
    );

    seqmis_judge #(.CW(CW)) judge_i (
        .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cnt(cnt_q),
        .lit_byte(prog_rd_data), .pkt_byte(pkt_rd_data),
        .differ(differ), .last_ok(last_ok), .finish(finish)
    );

    assign prog_rd_en   = issue;
    assign pkt_rd_en    = issue;
    assign prog_rd_addr = lit_q + AW'(idx);
    assign pkt_rd_addr  = off_q + PW'(idx);
    assign busy         = (st == ST_RUN);
    assign taken        = res_q.taken;
    assign bounds_err   = res_q.bounds;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            res_q   <= '0;
            next_pc <= '0;
            lit_q   <= '0;
            end_q   <= '0;
            tgt_q   <= '0;
            off_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    lit_q <= lit_addr;
                    off_q <= pkt_offset;
                    len_q <= pkt_len;
                    cnt_q <= byte_count;
                    end_q <= end_in;
                    tgt_q <= end_in + jump_off;
                    if (!fits) begin
                        done    <= 1'b1;
                        res_q   <= '{taken: 1'b0, bounds: 1'b1};
                        next_pc <= end_in;
                    end else if (byte_count == '0) begin
                        done    <= 1'b1;
                        res_q   <= '0;
                        next_pc <= lit_addr;
                    end else begin
                        st <= ST_RUN;
                    end
                end
                ST_RUN: if (finish) begin
                    st      <= ST_IDLE;
                    done    <= 1'b1;
                    res_q   <= '{taken: differ, bounds: 1'b0};
                    next_pc <= differ ? tgt_q : end_q;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Completion marker lasts a single cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Idle block drives no memory traffic.
    p_no_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!prog_rd_en && !pkt_rd_en));

    // Packet reads never leave the packet.
    p_pkt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        pkt_rd_en |-> ({1'b0, pkt_rd_addr} < {1'b0, len_q}));

    // A refused span never reports a taken branch.
    p_bounds_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (done && bounds_err) |-> !taken);

    // Results hold while idle without a new launch.
    p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start && !done) |=> ($stable(next_pc) && $stable(taken) && !done));

    // A start while running does not end or restart the run.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !finish) |=> (busy && !done));

endmodule

// File: tb/seqmis_cmp_tb.sv
`timescale 1ns/1ps
module seqmis_cmp_tb_top;
    localparam int AW = 16;
    localparam int PW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] lit_addr = '0, jump_off = '0;
    logic [PW-1:0] pkt_offset = '0, pkt_len = '0;
    logic [CW-1:0] byte_count = '0;
    logic          prog_rd_en, pkt_rd_en, busy, done, taken, bounds_err;
    logic [AW-1:0] prog_rd_addr, next_pc;
    logic [PW-1:0] pkt_rd_addr;
    logic [7:0]    prog_rd_data, pkt_rd_data;

    logic [7:0]    prog_mem [0:255];
    logic [7:0]    pkt_mem  [0:63];
    logic [AW-1:0] prog_log [0:63];
    logic [PW-1:0] pkt_log  [0:63];
    int            n_prog = 0;
    int            n_pkt  = 0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    seqmis_cmp #(.AW(AW), .PW(PW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .lit_addr(lit_addr), .jump_off(jump_off),
        .pkt_offset(pkt_offset), .pkt_len(pkt_len), .byte_count(byte_count),
        .prog_rd_en(prog_rd_en), .prog_rd_addr(prog_rd_addr), .prog_rd_data(prog_rd_data),
        .pkt_rd_en(pkt_rd_en), .pkt_rd_addr(pkt_rd_addr), .pkt_rd_data(pkt_rd_data),
        .busy(busy), .done(done), .taken(taken), .bounds_err(bounds_err),
        .next_pc(next_pc)
    );

    // Synchronous memory models with one-cycle read latency, plus issue logs.
    always_ff @(posedge clk) begin
        if (prog_rd_en) begin
            prog_rd_data <= prog_mem[prog_rd_addr[7:0]];
            prog_log[n_prog % 64] <= prog_rd_addr;
            n_prog <= n_prog + 1;
        end
        if (pkt_rd_en) begin
            pkt_rd_data <= pkt_mem[pkt_rd_addr[5:0]];
            pkt_log[n_pkt % 64] <= pkt_rd_addr;
            n_pkt <= n_pkt + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Launch one compare and check latency, outcome and read count.
    task automatic run_op(input string req,
                          input logic [AW-1:0] la, input logic [PW-1:0] off,
                          input logic [CW-1:0] n, input logic [AW-1:0] jo,
                          input logic [PW-1:0] len,
                          input int exp_lat, input bit exp_tk, input bit exp_be,
                          input logic [AW-1:0] exp_pc, input int exp_iss,
                          input bit inject, output int base);
        int lat;
        base = n_prog;
        lit_addr = la; pkt_offset = off; byte_count = n; jump_off = jo; pkt_len = len;
        start = 1'b1;
        lat = 0;
        for (int c = 1; c <= 40; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && c == 2) begin
                start = 1'b1; lit_addr = 16'd200; byte_count = '0; pkt_offset = '0;
            end
            if (done) begin
                lat = c;
                break;
            end
        end
        start = 1'b0;
        check(req, "done latency", lat, exp_lat);
        check(req, "taken", taken, exp_tk);
        check(req, "bounds_err", bounds_err, exp_be);
        check(req, "next_pc", next_pc, exp_pc);
        @(negedge clk);
        check(req, "prog reads", n_prog - base, exp_iss);
        check(req, "pkt reads", n_pkt - base, exp_iss);
    endtask

    task automatic t_reset;
        check("R1", "done", done, 0);
        check("R1", "busy", busy, 0);
        check("R1", "taken", taken, 0);
        check("R1", "bounds_err", bounds_err, 0);
        check("R1", "read enables", {prog_rd_en, pkt_rd_en}, 0);
        check("R1", "next_pc", next_pc, 0);
    endtask

    task automatic t_match;
        int b;
        run_op("R3", 16'd16, 16'd5, 16'd4, 16'd10, 16'd40, 6, 0, 0, 16'd20, 4, 0, b);
        for (int i = 0; i < 4; i++) begin
            check("R2", "prog addr", prog_log[(b + i) % 64], 16 + i);
            check("R2", "pkt addr", pkt_log[(b + i) % 64], 5 + i);
        end
    endtask

    task automatic t_mismatch_first;
        int b;
        prog_mem[16] = prog_mem[16] ^ 8'h01;
        run_op("R4", 16'd16, 16'd5, 16'd4, 16'd10, 16'd40, 3, 1, 0, 16'd30, 2, 0, b);
        prog_mem[16] = prog_mem[16] ^ 8'h01;
    endtask

    task automatic t_mismatch_msb;
        int b;
        prog_mem[19] = prog_mem[19] ^ 8'h80;  // R9: bit 7 only
        run_op("R9", 16'd16, 16'd5, 16'd4, 16'd10, 16'd40, 6, 1, 0, 16'd30, 4, 0, b);
        prog_mem[19] = prog_mem[19] ^ 8'h80;
    endtask

    task automatic t_zero;
        int b;
        run_op("R5", 16'd50, 16'd5, 16'd0, 16'd10, 16'd40, 1, 0, 0, 16'd50, 0, 0, b);
    endtask

    task automatic t_bounds;
        int b;
        run_op("R6", 16'd16, 16'd38, 16'd4, 16'd10, 16'd40, 1, 0, 1, 16'd20, 0, 0, b);
        // Exact fit at the packet end is accepted (R6).
        run_op("R6", 16'd100, 16'd36, 16'd4, 16'd10, 16'd40, 6, 0, 0, 16'd104, 4, 0, b);
    endtask

    task automatic t_wrap;
        int b;
        prog_mem[8'hFE] = pkt_mem[10];
        prog_mem[8'hFF] = pkt_mem[11] ^ 8'h10;
        run_op("R9", 16'hFFFE, 16'd10, 16'd2, 16'd5, 16'd40, 4, 1, 0, 16'h0005, 2, 0, b);
        check("R9", "wrapped addr", prog_log[(b + 1) % 64], 16'hFFFF);
    endtask

    task automatic t_hold;
        logic [AW-1:0] pc;
        logic tk;
        pc = next_pc; tk = taken;
        repeat (3) @(negedge clk);
        check("R7", "done after pulse", done, 0);
        check("R7", "next_pc held", next_pc, pc);
        check("R7", "taken held", taken, tk);
    endtask

    task automatic t_busy_start;
        int b;
        run_op("R8", 16'd16, 16'd5, 16'd4, 16'd10, 16'd40, 6, 0, 0, 16'd20, 4, 1, b);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) pkt_mem[i] = 8'((i * 37 + 11) & 8'hFF);
        for (int i = 0; i < 256; i++) prog_mem[i] = 8'hA5;
        for (int j = 0; j < 4; j++) begin
            prog_mem[16 + j]  = pkt_mem[5 + j];
            prog_mem[100 + j] = pkt_mem[36 + j];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_match;
        t_mismatch_first;
        t_mismatch_msb;
        t_hold;
        t_zero;
        t_bounds;
        t_wrap;
        t_busy_start;
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule